// File: doc/BRIEF.md
# Max-log-MAP State Metric Recursion Unit

This block is the soft-in/soft-out core of one half of an iterative decoder for a rate-1/3 parallel code whose constituent encoder is a 16-state recursive systematic convolutional code. The feedback polynomial is 1+D+D^2+D^3+D^4 and the parity polynomial is 1+D^4. A block of N trellis steps is streamed in. Each step carries a received soft systematic value, a received soft parity value and an a-priori log-likelihood value. For the first half iteration of a block, the a-priori value must be zero for every step.

After a start pulse, the unit runs the backward recursion over the stored block and keeps every backward metric vector. It then runs the forward recursion, holding only the current forward vector. While it does so it streams out one extrinsic value and one hard decision per step, in step order. Every state-metric update takes the larger of two branch sums, with no log-sum-exp correction. Every new 16-entry vector is normalized so that its largest entry is zero.

Both streams use valid/ready. An input symbol is taken on a cycle with `in_valid` and `in_ready` high. `in_ready` is held high during loading and is never withdrawn while a symbol is offered. An output step is retired on a cycle with `out_valid` and `out_ready` high. While `out_ready` is low, the offered step and its values are held unchanged. `start` and `done` are plain level signals sampled on the clock.

Top module: `maxlog_siso`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0. The unit takes exactly N symbols (step 0 first), one on each cycle with `in_valid` and `in_ready` both high. `in_ready` then stays 0 until the block has been fully output.
- R2: A `start` asserted before all N symbols are loaded has no effect: loading continues, `in_ready` stays 1 and `out_valid` stays 0.
- R3: Trellis and branch metric.
  - A state is 4 bits, and state 0 is the all-zero register.
  - The feedback bit is a = u XOR s[3] XOR s[2] XOR s[1] XOR s[0]. The parity bit is p = a XOR s[0]. The next state is {a, s[3:1]}.
  - The branch metric for input u and parity p is u·(x+La) + p·y. This differs from the bipolar half-sum only by a per-step constant, so it takes one of 4 values per step.
- R4: Initialization and normalization.
  - The backward recursion starts after step N-1, and the forward recursion starts before step 0. In both, state 0 starts at 0 and every other state starts at -2^(W-2).
  - Each new metric is the maximum over its two incoming branch sums, minus the maximum of all 16 such values.
  - A result below -2^(W-1) is clipped to -2^(W-1).
- R5: For step k, L = max over u=1 branches of (alpha_k(s)+gamma+beta_{k+1}(next)) minus the same maximum over u=0 branches. The extrinsic output is L - x - La, clipped to the W-bit signed range.
- R6: The hard decision is 1 when L > 0 and 0 otherwise.
- R7: The first `out_valid` comes exactly N clock edges after the edge that samples `start`. Steps are then offered in order 0..N-1, with `out_step` giving the index.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_ext`, `out_hard` and `out_step` hold their values into the next cycle.
- R9: `done` is 1 for exactly the one cycle after step N-1 is retired. In the following cycle `in_ready` is 1 again.
- R10: For a noiseless terminated codeword with zero a-priori input, the hard decisions equal the encoded information bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input symbol offered |
| in_ready | output | 1 | Unit accepts a symbol |
| in_sys | input | B | Received systematic value, signed |
| in_par | input | B | Received parity value, signed |
| in_apri | input | B | A-priori LLR, signed |
| start | input | 1 | Begin decoding the loaded block |
| out_valid | output | 1 | Output step offered |
| out_ready | input | 1 | Consumer takes the offered step |
| out_ext | output | W | Extrinsic value, signed |
| out_hard | output | 1 | Hard decision |
| out_step | output | $clog2(N) | Index of the offered step |
| done | output | 1 | One-cycle flag after the last step |

## Verification
The bench builds the unit with N=16, W=10 and B=8. A 16-step block holds 12 free information bits plus the 4 tail bits that drive the encoder back to state 0, so the tail-constrained end of both recursions is covered. The narrow 10-bit metrics put the -2^(W-1) metric floor and the extrinsic clip within reach of high-amplitude vectors. Small-amplitude vectors keep every value away from both limits. Vectors with a nonzero a-priori input, a flipped parity sample and stalled output cover the remaining paths.

// File: rtl/maxlog_pkg.sv
package maxlog_pkg;
  localparam int NST = 16;

  typedef enum logic [2:0] {PH_LOAD, PH_WAIT, PH_BWD, PH_FWD, PH_DONE} phase_t;

  // feedback bit entering the register for state s and input u
  function automatic logic fb_bit(input logic [3:0] s, input logic u);
    return u ^ (^s);
  endfunction

  function automatic logic [3:0] trel_next(input logic [3:0] s, input logic u);
    return {fb_bit(s, u), s[3:1]};
  endfunction

  function automatic logic trel_par(input logic [3:0] s, input logic u);
    return fb_bit(s, u) ^ s[0];
  endfunction

  // input bit that moves predecessor {ns[2:0], b} into ns
  function automatic logic pred_input(input logic [3:0] ns, input logic b);
    return ns[3] ^ (^{ns[2:0], b});
  endfunction
endpackage

// File: rtl/maxlog_branch.sv
module maxlog_branch #(
  parameter int B = 8
) (
  input  logic signed [B-1:0] sys,
  input  logic signed [B-1:0] par,
  input  logic signed [B-1:0] apri,
  output logic signed [B+1:0] gam [4]
);
  localparam int G = B + 2;

  logic signed [G-1:0] xa;
  logic signed [G-1:0] yy;

  assign xa = G'(sys) + G'(apri);
  assign yy = G'(par);

  // index {u, p}
  assign gam[0] = '0;
  assign gam[1] = yy;
  assign gam[2] = xa;
  assign gam[3] = xa + yy;
endmodule

// File: rtl/maxlog_stage.sv
module maxlog_stage
  import maxlog_pkg::*;
#(
  parameter int W        = 12,
  parameter int B        = 8,
  parameter bit BACKWARD = 1'b0
) (
  input  logic signed [W-1:0] m_in  [NST],
  input  logic signed [B+1:0] gam   [4],
  output logic signed [W-1:0] m_out [NST]
);
  localparam int D = W + B + 3;
  localparam logic signed [D-1:0] FLOOR   = D'(-(2 ** (W-1)));
  localparam logic signed [W-1:0] FLOOR_W = W'(-(2 ** (W-1)));

  logic signed [D-1:0] raw [NST];
  logic signed [D-1:0] nrm [NST];
  logic signed [D-1:0] peak;

  for (genvar s = 0; s < NST; s++) begin : g_acs
    logic signed [D-1:0] c0;
    logic signed [D-1:0] c1;
    if (BACKWARD) begin : g_bwd
      localparam logic [3:0] N0 = trel_next(4'(s), 1'b0);
      localparam logic [3:0] N1 = trel_next(4'(s), 1'b1);
      localparam int I0 = trel_par(4'(s), 1'b0) ? 1 : 0;
      localparam int I1 = trel_par(4'(s), 1'b1) ? 3 : 2;
      assign c0 = D'(m_in[N0]) + D'(gam[I0]);
      assign c1 = D'(m_in[N1]) + D'(gam[I1]);
    end else begin : g_fwd
      localparam logic [3:0] SV = 4'(s);
      localparam logic [3:0] P0 = {SV[2:0], 1'b0};
      localparam logic [3:0] P1 = {SV[2:0], 1'b1};
      localparam logic U0 = pred_input(SV, 1'b0);
      localparam logic U1 = pred_input(SV, 1'b1);
      localparam int I0 = (U0 ? 2 : 0) + (trel_par(P0, U0) ? 1 : 0);
      localparam int I1 = (U1 ? 2 : 0) + (trel_par(P1, U1) ? 1 : 0);
      assign c0 = D'(m_in[P0]) + D'(gam[I0]);
      assign c1 = D'(m_in[P1]) + D'(gam[I1]);
    end
    assign raw[s] = (c1 > c0) ? c1 : c0;
  end

  always_comb begin
    peak = raw[0];
    for (int i = 1; i < NST; i++) begin
      if (raw[i] > peak) peak = raw[i];
    end
  end

  always_comb begin
    for (int i = 0; i < NST; i++) begin
      nrm[i]   = raw[i] - peak;
      m_out[i] = (nrm[i] < FLOOR) ? FLOOR_W : nrm[i][W-1:0];
    end
  end
endmodule

// File: rtl/maxlog_llr.sv
module maxlog_llr
  import maxlog_pkg::*;
#(
  parameter int W = 12,
  parameter int B = 8
) (
  input  logic signed [W-1:0] alpha [NST],
  input  logic signed [W-1:0] beta  [NST],
  input  logic signed [B+1:0] gam   [4],
  input  logic signed [B-1:0] sys,
  input  logic signed [B-1:0] apri,
  output logic signed [W-1:0] ext,
  output logic                hard
);
  localparam int D = W + B + 3;
  localparam logic signed [D-1:0] HI   = D'((2 ** (W-1)) - 1);
  localparam logic signed [D-1:0] LO   = D'(-(2 ** (W-1)));
  localparam logic signed [W-1:0] HI_W = W'((2 ** (W-1)) - 1);
  localparam logic signed [W-1:0] LO_W = W'(-(2 ** (W-1)));

  logic signed [D-1:0] path [2*NST];
  logic signed [D-1:0] best0;
  logic signed [D-1:0] best1;
  logic signed [D-1:0] llr;
  logic signed [D-1:0] ext_raw;

  for (genvar s = 0; s < NST; s++) begin : g_st
    for (genvar u = 0; u < 2; u++) begin : g_in
      localparam logic [3:0] NS = trel_next(4'(s), 1'(u));
      localparam int GI = 2 * u + (trel_par(4'(s), 1'(u)) ? 1 : 0);
      assign path[2*s+u] = D'(alpha[s]) + D'(gam[GI]) + D'(beta[NS]);
    end
  end

  always_comb begin
    best0 = path[0];
    best1 = path[1];
    for (int s = 1; s < NST; s++) begin
      if (path[2*s]   > best0) best0 = path[2*s];
      if (path[2*s+1] > best1) best1 = path[2*s+1];
    end
  end

  assign llr     = best1 - best0;
  assign ext_raw = llr - D'(sys) - D'(apri);
  assign hard    = (llr > 0);

  always_comb begin
    if (ext_raw > HI)      ext = HI_W;
    else if (ext_raw < LO) ext = LO_W;
    else                   ext = ext_raw[W-1:0];
  end
endmodule

// File: rtl/maxlog_siso.sv
module maxlog_siso
  import maxlog_pkg::*;
#(
  parameter int N = 16,
  parameter int W = 12,
  parameter int B = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [B-1:0]     in_sys,
  input  logic signed [B-1:0]     in_par,
  input  logic signed [B-1:0]     in_apri,
  input  logic                    start,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [W-1:0]     out_ext,
  output logic                    out_hard,
  output logic [$clog2(N)-1:0]    out_step,
  output logic                    done
);
  localparam int IW = $clog2(N);
  localparam logic [IW-1:0] LAST = IW'(N - 1);
  localparam logic signed [W-1:0] NEG_INIT = W'(-(2 ** (W-2)));

  phase_t phase;
  logic [IW-1:0] idx;

  logic signed [B-1:0] sym_x [N];
  logic signed [B-1:0] sym_y [N];
  logic signed [B-1:0] sym_a [N];
  logic signed [W-1:0] bmem  [N][NST];

  logic signed [W-1:0] alpha_q [NST];
  logic signed [W-1:0] beta_q  [NST];
  logic signed [W-1:0] alpha_d [NST];
  logic signed [W-1:0] beta_d  [NST];
  logic signed [W-1:0] beta_rd [NST];

  logic signed [B-1:0] cur_x;
  logic signed [B-1:0] cur_y;
  logic signed [B-1:0] cur_a;
  logic signed [B+1:0] gam [4];

  logic load_fire;
  logic out_fire;

  assign in_ready  = (phase == PH_LOAD);
  assign out_valid = (phase == PH_FWD);
  assign done      = (phase == PH_DONE);
  assign out_step  = idx;
  assign load_fire = in_ready && in_valid;
  assign out_fire  = out_valid && out_ready;

  // sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_LOAD;
      idx   <= '0;
    end else begin
      case (phase)
        PH_LOAD: if (in_valid) begin
          if (idx == LAST) begin
            idx   <= '0;
            phase <= PH_WAIT;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        PH_WAIT: if (start) begin
          idx   <= LAST;
          phase <= PH_BWD;
        end
        PH_BWD: begin
          if (idx == '0) phase <= PH_FWD;
          else           idx   <= idx - 1'b1;
        end
        PH_FWD: if (out_ready) begin
          if (idx == LAST) begin
            idx   <= '0;
            phase <= PH_DONE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: phase <= PH_LOAD;
      endcase
    end
  end

  // symbol and backward-metric storage
  always_ff @(posedge clk) begin
    if (load_fire) begin
      sym_x[idx] <= in_sys;
      sym_y[idx] <= in_par;
      sym_a[idx] <= in_apri;
    end
    if (phase == PH_BWD) bmem[idx] <= beta_q;
  end

  always_comb begin
    cur_x   = sym_x[idx];
    cur_y   = sym_y[idx];
    cur_a   = sym_a[idx];
    beta_rd = bmem[idx];
  end

  // metric registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NST; i++) begin
        alpha_q[i] <= (i == 0) ? '0 : NEG_INIT;
        beta_q[i]  <= (i == 0) ? '0 : NEG_INIT;
      end
    end else begin
      if (phase == PH_WAIT && start) begin
        for (int i = 0; i < NST; i++) beta_q[i] <= (i == 0) ? '0 : NEG_INIT;
      end else if (phase == PH_BWD) begin
        beta_q <= beta_d;
      end
      if (phase == PH_BWD && idx == '0) begin
        for (int i = 0; i < NST; i++) alpha_q[i] <= (i == 0) ? '0 : NEG_INIT;
      end else if (out_fire) begin
        alpha_q <= alpha_d;
      end
    end
  end

  maxlog_branch #(.B(B)) u_branch (
    .sys (cur_x),
    .par (cur_y),
    .apri(cur_a),
    .gam (gam)
  );

  maxlog_stage #(.W(W), .B(B), .BACKWARD(1'b1)) u_bwd (
    .m_in (beta_q),
    .gam  (gam),
    .m_out(beta_d)
  );

  maxlog_stage #(.W(W), .B(B), .BACKWARD(1'b0)) u_fwd (
    .m_in (alpha_q),
    .gam  (gam),
    .m_out(alpha_d)
  );

  maxlog_llr #(.W(W), .B(B)) u_llr (
    .alpha(alpha_q),
    .beta (beta_rd),
    .gam  (gam),
    .sys  (cur_x),
    .apri (cur_a),
    .ext  (out_ext),
    .hard (out_hard)
  );

  // assertion support
  logic alpha_has_top;
  logic alpha_above;
  always_comb begin
    alpha_has_top = 1'b0;
    alpha_above   = 1'b0;
    for (int i = 0; i < NST; i++) begin
      if (alpha_q[i] == '0) alpha_has_top = 1'b1;
      if (alpha_q[i] > 0)   alpha_above   = 1'b1;
    end
  end

  AST_ALPHA_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (alpha_has_top && !alpha_above));  // R4
  AST_BETA_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_BWD && idx == LAST) |-> (beta_q[0] == '0 && beta_q[1] == NEG_INIT));  // R4
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ext) && $stable(out_hard) && $stable(out_step)));  // R8
  AST_STEP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && out_step != LAST) |=> (out_valid && out_step == $past(out_step) + 1'b1));  // R7
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_fire && out_step == LAST));  // R9
  AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && start) |=> (!out_valid));  // R2
endmodule

// File: tb/maxlog_siso_bench.sv
module maxlog_siso_bench;
  localparam int N  = 16;
  localparam int W  = 10;
  localparam int B  = 8;
  localparam int IW = $clog2(N);
  localparam int MINV = -(2 ** (W-1));
  localparam int MAXV = (2 ** (W-1)) - 1;
  localparam int NEGI = -(2 ** (W-2));
  localparam int NV = 8;

  // {info[11:0], amp[7:0], apri[7:0] signed, stall, chk_info, flip, 0}
  localparam logic [31:0] VEC [NV] = '{
    {12'hA5C, 8'd20,  8'h00, 4'b0100},
    {12'h000, 8'd20,  8'h00, 4'b1100},
    {12'hFFF, 8'd40,  8'h00, 4'b0100},
    {12'h3C7, 8'd120, 8'h00, 4'b1000},
    {12'h5A1, 8'd3,   8'h00, 4'b0100},
    {12'h9E2, 8'd25,  8'h06, 4'b0000},
    {12'h71B, 8'd30,  8'hF6, 4'b1000},
    {12'hC3D, 8'd20,  8'h00, 4'b0010}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [B-1:0] in_sys = '0;
  logic signed [B-1:0] in_par = '0;
  logic signed [B-1:0] in_apri = '0;
  logic start = 1'b0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic signed [W-1:0] out_ext;
  logic out_hard;
  logic [IW-1:0] out_step;
  logic done;

  int total = 0;
  int bad = 0;

  int xs [N];
  int ys [N];
  int las [N];
  int ubit [N];
  int alp [N+1][16];
  int bet [N+1][16];
  int exp_ext [N];
  int exp_bit [N];

  always #4 clk = ~clk;

  maxlog_siso #(.N(N), .W(W), .B(B)) u_maxlog_siso (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_sys(in_sys), .in_par(in_par), .in_apri(in_apri),
    .start(start),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_ext(out_ext), .out_hard(out_hard), .out_step(out_step),
    .done(done)
  );

  task automatic chk(input bit ok, input string what, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
    end
  endtask

  // trellis as written in R3
  function automatic int fbk(int s, int u);
    return u ^ ((s >> 3) & 1) ^ ((s >> 2) & 1) ^ ((s >> 1) & 1) ^ (s & 1);
  endfunction
  function automatic int nxt(int s, int u);
    return (fbk(s, u) << 3) | (s >> 1);
  endfunction
  function automatic int pbit(int s, int u);
    return fbk(s, u) ^ (s & 1);
  endfunction
  function automatic int gm(int k, int s, int u);
    return (u != 0 ? xs[k] + las[k] : 0) + (pbit(s, u) != 0 ? ys[k] : 0);
  endfunction

  task automatic build_model();
    int raw [16];
    int pk;
    for (int s = 0; s < 16; s++) begin
      bet[N][s] = (s == 0) ? 0 : NEGI;
      alp[0][s] = (s == 0) ? 0 : NEGI;
    end
    for (int k = N - 1; k >= 1; k--) begin
      for (int s = 0; s < 16; s++) begin
        int a0, a1;
        a0 = gm(k, s, 0) + bet[k+1][nxt(s, 0)];
        a1 = gm(k, s, 1) + bet[k+1][nxt(s, 1)];
        raw[s] = (a1 > a0) ? a1 : a0;
      end
      pk = raw[0];
      for (int s = 1; s < 16; s++) if (raw[s] > pk) pk = raw[s];
      for (int s = 0; s < 16; s++) bet[k][s] = (raw[s] - pk < MINV) ? MINV : raw[s] - pk;
    end
    for (int k = 0; k < N; k++) begin
      int m0, m1, l, e;
      m0 = -1000000; m1 = -1000000;
      for (int s = 0; s < 16; s++) raw[s] = -1000000;
      for (int s = 0; s < 16; s++) begin
        for (int u = 0; u < 2; u++) begin
          int f, t;
          f = alp[k][s] + gm(k, s, u);
          t = f + bet[k+1][nxt(s, u)];
          if (u == 1) begin if (t > m1) m1 = t; end
          else begin if (t > m0) m0 = t; end
          if (f > raw[nxt(s, u)]) raw[nxt(s, u)] = f;
        end
      end
      l = m1 - m0;
      e = l - xs[k] - las[k];
      exp_ext[k] = (e > MAXV) ? MAXV : ((e < MINV) ? MINV : e);
      exp_bit[k] = (l > 0) ? 1 : 0;
      pk = raw[0];
      for (int s = 1; s < 16; s++) if (raw[s] > pk) pk = raw[s];
      for (int s = 0; s < 16; s++) alp[k+1][s] = (raw[s] - pk < MINV) ? MINV : raw[s] - pk;
    end
  endtask

  task automatic run_block(input int e);
    logic [31:0] v;
    int amp, la, st, lat, step, cyc, h_ext, h_step, hold;
    bit stall, chk_info, flip;
    v = VEC[e];
    amp = int'(v[19:12]);
    la = int'($signed(v[11:4]));
    stall = v[3]; chk_info = v[2]; flip = v[1];
    st = 0;
    for (int k = 0; k < N; k++) begin
      int u, p;
      u = (k < N - 4) ? int'(v[20 + k]) : fbk(st, 0);
      p = pbit(st, u);
      st = nxt(st, u);
      ubit[k] = u;
      xs[k] = u != 0 ? amp : -amp;
      ys[k] = p != 0 ? amp : -amp;
      if (flip && k == 5) ys[k] = -ys[k];
      las[k] = (k % 2 == 1) ? la : -la;
    end
    build_model();

    for (int k = 0; k < N; k++) begin
      in_valid = 1'b1;
      in_sys = B'(xs[k]); in_par = B'(ys[k]); in_apri = B'(las[k]);
      chk(in_ready == 1'b1, "R1 in_ready while loading", int'(in_ready), 1);
      @(posedge clk); @(negedge clk);
      if (e == 0 && k == 4) begin
        in_valid = 1'b0;
        start = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        for (int j = 0; j < 3; j++) begin
          chk(in_ready == 1'b1, "R2 early start keeps loading", int'(in_ready), 1);
          chk(out_valid == 1'b0, "R2 early start no output", int'(out_valid), 0);
          @(posedge clk); @(negedge clk);
        end
      end
    end
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R1 in_ready low after N symbols", int'(in_ready), 0);

    start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!out_valid && lat < 4 * N) begin
      @(posedge clk); @(negedge clk);
      lat++;
    end
    chk(lat == N, "R7 latency from start", lat, N);

    step = 0; cyc = 0; hold = 0; h_ext = 0; h_step = 0;
    while (step < N && cyc < 8 * N) begin
      if (hold != 0) begin
        chk(out_valid == 1'b1 && int'(out_ext) == h_ext && int'(out_step) == h_step,
            "R8 output held under stall", int'(out_ext), h_ext);
      end
      out_ready = stall ? cyc[0] : 1'b1;
      chk(out_valid == 1'b1, "R7 valid during output", int'(out_valid), 1);
      chk(int'(out_step) == step, "R7 step order", int'(out_step), step);
      if (out_ready) begin
        chk(int'(out_ext) == exp_ext[step], $sformatf("R5 extrinsic vec %0d step %0d", e, step),
            int'(out_ext), exp_ext[step]);
        chk(int'(out_hard) == exp_bit[step], $sformatf("R6 hard vec %0d step %0d", e, step),
            int'(out_hard), exp_bit[step]);
        if (chk_info)
          chk(int'(out_hard) == ubit[step], $sformatf("R10 decoded bit vec %0d step %0d", e, step),
              int'(out_hard), ubit[step]);
        step++;
        hold = 0;
      end else begin
        hold = 1; h_ext = int'(out_ext); h_step = int'(out_step);
      end
      cyc++;
      @(posedge clk); @(negedge clk);
    end
    chk(done == 1'b1, "R9 done after last step", int'(done), 1);
    chk(out_valid == 1'b0, "R9 no output after last step", int'(out_valid), 0);
    out_ready = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(done == 1'b0, "R9 done lasts one cycle", int'(done), 0);
    chk(in_ready == 1'b1, "R9 ready for next block", int'(in_ready), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(in_ready == 1'b1, "R1 reset in_ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
    chk(done == 1'b0, "R9 reset done", int'(done), 0);
    for (int e = 0; e < NV; e++) run_block(e);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule